// File: doc/BRIEF.md
# Universal Latched/Registered Bus Transceiver

This block moves an 18-bit word between two buses, A and B, in either direction, without inverting it. Each direction has its own storage element and its own four controls: a drive-enable (active low), a latch-enable, a strobe, and a strobe-gate (active low). While the latch-enable is high, the element is transparent and the input reaches the output through a combinational bypass. While it is low, the element works as an edge-triggered register that loads on a rising strobe, but only when the strobe-gate is low.

Pads are split into separate input, output and drive-enable vectors, and a wrapper resolves them to tri-state. Every control and data input is sampled on one system clock. A strobe rising edge is a cycle in which the strobe is sampled high after being sampled low. An active-high reset clears both storage elements and holds both drive-enables off.

The controls are plain level pins and the data ports carry no handshake, because a pad cannot apply back-pressure. The data path therefore has no valid/ready interface.

Top module: `univ_xcvr`

## Requirements
- R1: While `rst` is high, `a_pad_drv` and `b_pad_drv` are 0 whatever the controls are. After reset, both storage elements hold 0.
- R2: When a direction's drive-enable (`ab_oe_n` / `ba_oe_n`) is 1, that direction's drive output is 0. When it is 0 and reset is low, the drive output is 1.
- R3: The drive-enable has no effect on stored data. A value loaded while the output is disabled appears once the output is enabled again, and toggling the enable leaves the value unchanged.
- R4: While a direction's latch-enable is 1, its output equals its input in the same cycle, for every bit and whatever the strobe and strobe-gate do. The path does not invert.
- R5: With latch-enable 0 and strobe-gate 0, a strobe rising edge (sampled 0, then sampled 1) loads the input sampled at that clock edge. The new value is visible from that edge on.
- R6: With latch-enable 0 and the strobe held at 1 or at 0, and also on a falling strobe, the stored value does not change.
- R7: While the strobe-gate is 1, strobe rising edges are ignored and the stored value is kept.
- R8: When the latch-enable falls while the strobe is low, the element keeps the input that was present on the last clock edge with latch-enable high.
- R9: Activity in one direction never changes the value stored in the other direction.
- R10: If a strobe is already high when reset is released, no load takes place, even with the strobe-gate open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every input |
| rst | input | 1 | Active-high reset; clears storage and disables drivers |
| a_pad_i | input | 18 | Data arriving from bus A |
| a_pad_o | output | 18 | Data sent toward bus A (B-to-A path) |
| a_pad_drv | output | 1 | 1 = drive bus A with `a_pad_o` |
| b_pad_i | input | 18 | Data arriving from bus B |
| b_pad_o | output | 18 | Data sent toward bus B (A-to-B path) |
| b_pad_drv | output | 1 | 1 = drive bus B with `b_pad_o` |
| ab_oe_n | input | 1 | A-to-B drive-enable, active low |
| ab_le | input | 1 | A-to-B latch-enable (1 = transparent) |
| ab_cp | input | 1 | A-to-B strobe; rising edge loads |
| ab_ce_n | input | 1 | A-to-B strobe-gate, active low |
| ba_oe_n | input | 1 | B-to-A drive-enable, active low |
| ba_le | input | 1 | B-to-A latch-enable (1 = transparent) |
| ba_cp | input | 1 | B-to-A strobe; rising edge loads |
| ba_ce_n | input | 1 | B-to-A strobe-gate, active low |

## Verification
Each direction is driven in turn through transparent tracking with all-ones, all-zeros and mixed words, so a stuck, swapped or inverted bit shows up. The sequence then covers a latch-enable fall with the strobe low, a gated rising edge, a held strobe, a falling strobe and an ungated edge. These separate "loaded on the rise" from "loaded on any change" and from "loaded regardless of the gate". Loads made while the output is disabled, and a strobe already high at reset release, show whether the enable or reset leak into storage. A word parked in the opposite direction is re-read after each run to catch cross-talk between the two elements.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int NUM_DIR = 2;

  typedef enum logic [0:0] {
    DIR_A2B = 1'b0,
    DIR_B2A = 1'b1
  } xfer_dir_e;

  // per-direction control bundle, all sampled on the system clock
  typedef struct packed {
    logic drv_n;   // output drive enable, active low
    logic transp;  // 1 = transparent, 0 = edge-register
    logic strobe;  // load strobe, rising edge active
    logic gate_n;  // strobe gate, active low
  } lane_ctl_t;
endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic rise
);
  logic strobe_q;

  // follows the strobe during reset too, so a level already high at
  // release is not mistaken for an edge
  always_ff @(posedge clk) begin
    strobe_q <= strobe;
  end

  assign rise = strobe & ~strobe_q;

  // R6: two rising edges can never be reported back to back
  p_no_double_rise_r6: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/xcvr_store_cell.sv
module xcvr_store_cell #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         transp,
  input  logic         gate_n,
  input  logic         rise,
  output logic [W-1:0] q
);
  logic load;

  assign load = transp | (rise & ~gate_n);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end

  // R4/R8: while transparent the element tracks the input
  p_track_r4: assert property (@(posedge clk) disable iff (rst)
    transp |=> q == $past(din));
  // R5: gated rising edge captures the input
  p_load_r5: assert property (@(posedge clk) disable iff (rst)
    (!transp && !gate_n && rise) |=> q == $past(din));
  // R6: no edge, no change
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!transp && !rise) |=> $stable(q));
  // R7: closed gate blocks the edge
  p_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (!transp && gate_n) |=> $stable(q));
endmodule

// File: rtl/xcvr_out_stage.sv
module xcvr_out_stage #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         drv_n,
  input  logic         transp,
  input  logic [W-1:0] din,
  input  logic [W-1:0] held,
  output logic [W-1:0] dout,
  output logic         drv
);
  assign dout = transp ? din : held;
  assign drv  = ~drv_n & ~rst;

  // R1: drivers stay off through reset
  p_drv_off_r1: assert property (@(posedge clk)
    rst |-> !drv);
  // R2: disabled lane never drives
  p_disable_r2: assert property (@(posedge clk) disable iff (rst)
    drv_n |-> !drv);
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  lane_ctl_t    ctl,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         drv
);
  logic         rise;
  logic [W-1:0] held;

  xcvr_edge_det u_edge (
    .clk    (clk),
    .rst    (rst),
    .strobe (ctl.strobe),
    .rise   (rise)
  );

  xcvr_store_cell #(.W(W)) u_cell (
    .clk    (clk),
    .rst    (rst),
    .din    (din),
    .transp (ctl.transp),
    .gate_n (ctl.gate_n),
    .rise   (rise),
    .q      (held)
  );

  xcvr_out_stage #(.W(W)) u_out (
    .clk    (clk),
    .rst    (rst),
    .drv_n  (ctl.drv_n),
    .transp (ctl.transp),
    .din    (din),
    .held   (held),
    .dout   (dout),
    .drv    (drv)
  );
endmodule

// File: rtl/univ_xcvr.sv
module univ_xcvr
  import xcvr_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] a_pad_i,
  output logic [DATA_W-1:0] a_pad_o,
  output logic              a_pad_drv,
  input  logic [DATA_W-1:0] b_pad_i,
  output logic [DATA_W-1:0] b_pad_o,
  output logic              b_pad_drv,
  input  logic              ab_oe_n,
  input  logic              ab_le,
  input  logic              ab_cp,
  input  logic              ab_ce_n,
  input  logic              ba_oe_n,
  input  logic              ba_le,
  input  logic              ba_cp,
  input  logic              ba_ce_n
);
  lane_ctl_t         ctl  [NUM_DIR];
  logic [DATA_W-1:0] din  [NUM_DIR];
  logic [DATA_W-1:0] dout [NUM_DIR];
  logic              drv  [NUM_DIR];

  assign ctl[DIR_A2B] = '{drv_n: ab_oe_n, transp: ab_le, strobe: ab_cp, gate_n: ab_ce_n};
  assign ctl[DIR_B2A] = '{drv_n: ba_oe_n, transp: ba_le, strobe: ba_cp, gate_n: ba_ce_n};
  assign din[DIR_A2B] = a_pad_i;
  assign din[DIR_B2A] = b_pad_i;

  // R9: each direction owns an independent lane
  for (genvar g = 0; g < NUM_DIR; g++) begin : g_lane
    xcvr_lane #(.W(DATA_W)) u_lane (
      .clk  (clk),
      .rst  (rst),
      .ctl  (ctl[g]),
      .din  (din[g]),
      .dout (dout[g]),
      .drv  (drv[g])
    );
  end

  assign b_pad_o   = dout[DIR_A2B];
  assign b_pad_drv = drv[DIR_A2B];
  assign a_pad_o   = dout[DIR_B2A];
  assign a_pad_drv = drv[DIR_B2A];
endmodule

// File: tb/univ_xcvr_bench.sv
`timescale 1ns/1ps
module univ_xcvr_bench;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;   // 125 MHz

  logic [W-1:0] din [2];
  logic oe_n [2];
  logic le   [2];
  logic cp   [2];
  logic ce_n [2];
  logic [W-1:0] a_o, b_o;
  logic a_drv, b_drv;

  univ_xcvr #(.DATA_W(W)) u_univ_xcvr (
    .clk(clk), .rst(rst),
    .a_pad_i(din[0]), .a_pad_o(a_o), .a_pad_drv(a_drv),
    .b_pad_i(din[1]), .b_pad_o(b_o), .b_pad_drv(b_drv),
    .ab_oe_n(oe_n[0]), .ab_le(le[0]), .ab_cp(cp[0]), .ab_ce_n(ce_n[0]),
    .ba_oe_n(oe_n[1]), .ba_le(le[1]), .ba_cp(cp[1]), .ba_ce_n(ce_n[1])
  );

  typedef struct {
    string        req;
    int           dir;
    bit           chk_val;
    logic [W-1:0] val;
    logic         drv;
  } exp_t;

  exp_t q_exp[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  // monitor: compares pending expectations between clock edges
  initial begin
    forever begin
      @(negedge clk);
      while (q_exp.size() > 0) begin
        exp_t e;
        logic [W-1:0] av;
        logic ad;
        e  = q_exp.pop_front();
        av = (e.dir == 0) ? b_o : a_o;
        ad = (e.dir == 0) ? b_drv : a_drv;
        checks++;
        if (ad !== e.drv || (e.chk_val && av !== e.val)) begin
          failures++;
          $display("FAIL %s dir=%0d: data=%h drv=%b expected data=%h drv=%b",
                   e.req, e.dir, av, ad, e.val, e.drv);
        end
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // driver side: queue an expectation and let the monitor consume it
  task automatic expect_out(string req, int d, bit cv, logic [W-1:0] v, logic dv);
    exp_t e;
    e.req = req; e.dir = d; e.chk_val = cv; e.val = v; e.drv = dv;
    q_exp.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic run_dir(int d);
    cp[d] = 0; ce_n[d] = 1; oe_n[d] = 0;
    tick();
    // R4: transparent, full-width patterns, same cycle
    le[d] = 1; cp[d] = 1; din[d] = 18'h3FFFF;
    expect_out("R4", d, 1, 18'h3FFFF, 1);
    cp[d] = 0; ce_n[d] = 0; din[d] = 18'h00000;
    expect_out("R4", d, 1, 18'h00000, 1);
    ce_n[d] = 1; din[d] = 18'h15A5A;
    expect_out("R4", d, 1, 18'h15A5A, 1);
    // R8: close latch with strobe low, then change input
    tick();
    le[d] = 0;
    tick();
    din[d] = 18'h2C3F1;
    tick();
    expect_out("R8", d, 1, 18'h15A5A, 1);
    // R5: gated rising edge loads
    ce_n[d] = 0; cp[d] = 1;
    tick();
    expect_out("R5", d, 1, 18'h2C3F1, 1);
    // R6: strobe held high, then falling edge
    din[d] = 18'h3E01D;
    tick(3);
    expect_out("R6", d, 1, 18'h2C3F1, 1);
    cp[d] = 0;
    tick(2);
    expect_out("R6", d, 1, 18'h2C3F1, 1);
    // R7: gate closed, edge ignored
    ce_n[d] = 1; cp[d] = 1;
    tick(2);
    expect_out("R7", d, 1, 18'h2C3F1, 1);
    cp[d] = 0;
    tick();
    // R2: disable drive
    oe_n[d] = 1;
    tick();
    expect_out("R2", d, 0, '0, 0);
    // R3: load while disabled, then re-enable
    din[d] = 18'h0BEEF; ce_n[d] = 0; cp[d] = 1;
    tick();
    cp[d] = 0; ce_n[d] = 1; din[d] = 18'h1D00D;
    tick();
    oe_n[d] = 0;
    expect_out("R3", d, 1, 18'h0BEEF, 1);
    oe_n[d] = 1; tick(); oe_n[d] = 0; tick();
    expect_out("R3", d, 1, 18'h0BEEF, 1);
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      din[i] = 18'h30F0F; oe_n[i] = 0; le[i] = 0; cp[i] = 1; ce_n[i] = 0;
    end
    // R1: drivers off during reset even with drive enabled
    tick(3);
    expect_out("R1", 0, 0, '0, 0);
    expect_out("R1", 1, 0, '0, 0);
    // R10: strobes high at release with gate open -> no load
    rst = 0;
    tick(3);
    expect_out("R10", 0, 1, 18'h00000, 1);
    expect_out("R10", 1, 1, 18'h00000, 1);
    for (int i = 0; i < 2; i++) begin cp[i] = 0; ce_n[i] = 1; end
    tick();

    // park a word in B-to-A, exercise A-to-B, then confirm (R9)
    le[1] = 1; din[1] = 18'h00001; tick(); le[1] = 0; tick();
    oe_n[1] = 0;
    run_dir(0);
    expect_out("R9", 1, 1, 18'h00001, 1);

    // park a word in A-to-B, exercise B-to-A, then confirm (R9)
    le[0] = 1; din[0] = 18'h2AAAA; tick(); le[0] = 0; tick();
    oe_n[0] = 0;
    run_dir(1);
    expect_out("R9", 0, 1, 18'h2AAAA, 1);

    @(negedge clk); #1;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule